// File: doc/BRIEF.md
# Coprocessor Banked Window Address Mapper

This block sits between an 8-bit coprocessor and everything it can address. It decodes each coprocessor access to one of five places: its own 8 KB RAM, an FM sound chip, a PSG sound chip, a 9-bit bank register, or a 32 KB window into a 24-bit main address space. Each access goes out on a dedicated strobe. Reads from a place with no mapping return zero. The RAM occupies the bottom 16 KB and is indexed by the low 13 address bits, so it appears twice.

The bank register has no parallel load. Each write to its range shifts the register right by one and puts bit 0 of the written byte into the top bit, so a full page number takes nine writes. A window access sends the main bus the bank value joined to the low 15 coprocessor address bits. It holds a byte request until the main bus acknowledges, and keeps the coprocessor stalled for that time.

A 16-bit coprocessor access runs as two byte accesses, one after the other. The low byte uses the given address and the high byte uses the next address, wrapping at 0xFFFF. The two bytes may fall in different regions.

Top module: `cop_addr_map`

## Requirements
- R1: Addresses 0x0000-0x3FFF reach the local RAM with `ram_addr_o` equal to address bits 12:0, so 0x0123 and 0x2123 hit the same byte. Reads return `ram_rdata_i`.
- R2: Addresses 0x4000-0x5FFF reach the FM chip with `fm_addr_o` equal to address bits 1:0. A read returns `fm_status_i` and pulses `fm_re_o`. A write pulses `fm_we_o` with the byte.
- R3: A write to an address whose upper byte is 0x60 shifts the 9-bit bank right by one and loads data bit 0 into bank bit 8. The bank is 0 after reset. Such a write pulses no strobe.
- R4: A write to an address with (address AND 0xFFF9) = 0x7F11 pulses `psg_we_o` with the byte. A read of those addresses returns 0.
- R5: Addresses 0x8000-0xFFFF reach the main bus with `mbus_addr_o` = {bank, address bits 14:0}. This holds for both reads and writes.
- R6: `mbus_req_o` stays high with a stable address until `mbus_ack_i`, and `cop_wait_o` is high for that whole time. Read data is taken from `mbus_rdata_i` in the acknowledge cycle.
- R7: Reads of unmapped addresses (for example 0x6100-0x7FFF other than the sound range, or bank-range reads) return 0. Unmapped writes pulse no strobe.
- R8: When `cop_wide_i` is set, the access becomes a low byte at the address and a high byte at address+1 (wrapping at 0xFFFF). Write data bits 7:0 go first. Read data returns as {high byte, low byte}.
- R9: A single-cycle `cop_req_i` in an idle cycle starts an access, and `cop_wait_o` is high from the next cycle until the access ends. `cop_done_o` then pulses for one cycle with `cop_rdata_o`. A byte read has bits 15:8 zero. After reset no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cop_req_i | input | 1 | Start-of-access pulse |
| cop_we_i | input | 1 | Access is a write |
| cop_wide_i | input | 1 | 16-bit access |
| cop_addr_i | input | 16 | Coprocessor address |
| cop_wdata_i | input | 16 | Write data (bits 7:0 for byte access) |
| cop_rdata_o | output | 16 | Read data, valid with done |
| cop_wait_o | output | 1 | Coprocessor stall |
| cop_done_o | output | 1 | Access finished |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 13 | RAM byte index |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_rdata_i | input | 8 | RAM read byte |
| fm_re_o | output | 1 | FM status read strobe |
| fm_we_o | output | 1 | FM write strobe |
| fm_addr_o | output | 2 | FM register port select |
| fm_wdata_o | output | 8 | FM write byte |
| fm_status_i | input | 8 | FM status byte |
| psg_we_o | output | 1 | PSG write strobe |
| psg_wdata_o | output | 8 | PSG write byte |
| mbus_req_o | output | 1 | Main bus byte request |
| mbus_we_o | output | 1 | Main bus write |
| mbus_addr_o | output | 24 | Main bus byte address |
| mbus_wdata_o | output | 8 | Main bus write byte |
| mbus_rdata_i | input | 8 | Main bus read byte |
| mbus_ack_i | input | 1 | Main bus acknowledge |

## Verification
The bank register can only be seen through the upper bits of a later main-bus address. The hard case is a 16-bit write at 0x60FF: only its first byte falls in the bank range and shifts the register. The stimulus loads a known page with nine single-bit writes, then issues that split write, then a window read, and compares the resulting page with a model that tracks every shift. A 16-bit read at 0xFFFF covers the case where one access wraps from the window into RAM. It runs while the acknowledge is delayed by several cycles, so the held request is checked as well.

// File: rtl/cop_map_pkg.sv
package cop_map_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_FM,
    TGT_PSG,
    TGT_BANK,
    TGT_WIN
  } tgt_e;

  typedef enum logic {
    SQ_IDLE,
    SQ_EXEC
  } sq_e;
endpackage

// File: rtl/cop_addr_decode.sv
module cop_addr_decode
  import cop_map_pkg::*;
(
  input  logic [CPU_AW-1:0] addr_i,
  input  logic              we_i,
  output tgt_e              tgt_o
);
  localparam logic [CPU_AW-1:0] PSG_MASK  = 16'hFFF9;
  localparam logic [CPU_AW-1:0] PSG_MATCH = 16'h7F11;
  localparam logic [7:0]        BANK_PAGE = 8'h60;

  always_comb begin
    tgt_o = TGT_NONE;
    if (addr_i[15]) begin
      tgt_o = TGT_WIN;
    end else if (addr_i[15:14] == 2'b00) begin
      tgt_o = TGT_RAM;
    end else if (addr_i[15:13] == 3'b010) begin
      tgt_o = TGT_FM;
    end else if (addr_i[15:8] == BANK_PAGE) begin
      // bank range is write-only; reads fall through to zero
      tgt_o = we_i ? TGT_BANK : TGT_NONE;
    end else if ((addr_i & PSG_MASK) == PSG_MATCH) begin
      tgt_o = we_i ? TGT_PSG : TGT_NONE;
    end
  end
endmodule

// File: rtl/cop_bank_reg.sv
module cop_bank_reg #(
  parameter int unsigned BANK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
    end else if (shift_i) begin
      bank_o <= {bit_i, bank_o[BANK_W-1:1]};
    end
  end
endmodule

// File: rtl/cop_access_seq.sv
module cop_access_seq
  import cop_map_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [CPU_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  tgt_e              tgt_i,
  input  logic              win_ack_i,
  input  logic [BYTE_W-1:0] byte_rdata_i,
  output logic [CPU_AW-1:0] cur_addr_o,
  output logic              cur_we_o,
  output logic [BYTE_W-1:0] cur_wdata_o,
  output logic              active_o,
  output logic              step_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              done_o
);
  sq_e               state_q;
  logic [CPU_AW-1:0] base_q;
  logic [WORD_W-1:0] wdata_q;
  logic              we_q, wide_q, idx_q;
  logic [BYTE_W-1:0] lo_q;
  logic              last_byte;

  assign active_o    = (state_q == SQ_EXEC);
  assign cur_addr_o  = base_q + CPU_AW'(idx_q);
  assign cur_we_o    = we_q;
  assign cur_wdata_o = idx_q ? wdata_q[WORD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
  // a window byte completes only on acknowledge, all local bytes in one cycle
  assign step_o      = active_o && ((tgt_i != TGT_WIN) || win_ack_i);
  assign last_byte   = !wide_q || idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      base_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      idx_q   <= 1'b0;
      lo_q    <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (req_i) begin
            base_q  <= addr_i;
            wdata_q <= wdata_i;
            we_q    <= we_i;
            wide_q  <= wide_i;
            idx_q   <= 1'b0;
            state_q <= SQ_EXEC;
          end
        end
        SQ_EXEC: begin
          if (step_o) begin
            if (!idx_q) lo_q <= byte_rdata_i;
            if (last_byte) begin
              state_q <= SQ_IDLE;
              done_o  <= 1'b1;
              if (we_q)        rdata_o <= '0;
              else if (wide_q) rdata_o <= {byte_rdata_i, lo_q};
              else             rdata_o <= {{BYTE_W{1'b0}}, byte_rdata_i};
            end else begin
              idx_q <= 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cop_addr_map.sv
module cop_addr_map
  import cop_map_pkg::*;
#(
  parameter int unsigned MAIN_AW = 24,
  parameter int unsigned WIN_AW  = 15,
  parameter int unsigned RAM_AW  = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cop_req_i,
  input  logic               cop_we_i,
  input  logic               cop_wide_i,
  input  logic [15:0]        cop_addr_i,
  input  logic [15:0]        cop_wdata_i,
  output logic [15:0]        cop_rdata_o,
  output logic               cop_wait_o,
  output logic               cop_done_o,
  output logic               ram_re_o,
  output logic               ram_we_o,
  output logic [RAM_AW-1:0]  ram_addr_o,
  output logic [7:0]         ram_wdata_o,
  input  logic [7:0]         ram_rdata_i,
  output logic               fm_re_o,
  output logic               fm_we_o,
  output logic [1:0]         fm_addr_o,
  output logic [7:0]         fm_wdata_o,
  input  logic [7:0]         fm_status_i,
  output logic               psg_we_o,
  output logic [7:0]         psg_wdata_o,
  output logic               mbus_req_o,
  output logic               mbus_we_o,
  output logic [MAIN_AW-1:0] mbus_addr_o,
  output logic [7:0]         mbus_wdata_o,
  input  logic [7:0]         mbus_rdata_i,
  input  logic               mbus_ack_i
);
  localparam int unsigned BANK_W = MAIN_AW - WIN_AW;

  logic [CPU_AW-1:0] cur_addr;
  logic              cur_we, active, step;
  logic [BYTE_W-1:0] cur_wdata, byte_rdata;
  logic [BANK_W-1:0] bank;
  tgt_e              tgt;

  cop_addr_decode u_dec (
    .addr_i (cur_addr),
    .we_i   (cur_we),
    .tgt_o  (tgt)
  );

  cop_access_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cop_req_i),
    .we_i         (cop_we_i),
    .wide_i       (cop_wide_i),
    .addr_i       (cop_addr_i),
    .wdata_i      (cop_wdata_i),
    .tgt_i        (tgt),
    .win_ack_i    (mbus_ack_i),
    .byte_rdata_i (byte_rdata),
    .cur_addr_o   (cur_addr),
    .cur_we_o     (cur_we),
    .cur_wdata_o  (cur_wdata),
    .active_o     (active),
    .step_o       (step),
    .rdata_o      (cop_rdata_o),
    .done_o       (cop_done_o)
  );

  cop_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (step && (tgt == TGT_BANK)),
    .bit_i   (cur_wdata[0]),
    .bank_o  (bank)
  );

  always_comb begin
    unique case (tgt)
      TGT_RAM: byte_rdata = ram_rdata_i;
      TGT_FM:  byte_rdata = fm_status_i;
      TGT_WIN: byte_rdata = mbus_rdata_i;
      default: byte_rdata = '0;
    endcase
  end

  assign cop_wait_o   = active;
  assign ram_re_o     = active && (tgt == TGT_RAM) && !cur_we;
  assign ram_we_o     = active && (tgt == TGT_RAM) &&  cur_we;
  assign ram_addr_o   = cur_addr[RAM_AW-1:0];
  assign ram_wdata_o  = cur_wdata;
  assign fm_re_o      = active && (tgt == TGT_FM) && !cur_we;
  assign fm_we_o      = active && (tgt == TGT_FM) &&  cur_we;
  assign fm_addr_o    = cur_addr[1:0];
  assign fm_wdata_o   = cur_wdata;
  assign psg_we_o     = active && (tgt == TGT_PSG);
  assign psg_wdata_o  = cur_wdata;
  assign mbus_req_o   = active && (tgt == TGT_WIN);
  assign mbus_we_o    = cur_we;
  assign mbus_addr_o  = {bank, cur_addr[WIN_AW-1:0]};
  assign mbus_wdata_o = cur_wdata;
endmodule

// File: rtl/cop_addr_map_chk.sv
module cop_addr_map_chk #(
  parameter int unsigned MAIN_AW = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cop_wait_o,
  input logic               cop_done_o,
  input logic               ram_re_o,
  input logic               ram_we_o,
  input logic               fm_re_o,
  input logic               fm_we_o,
  input logic               psg_we_o,
  input logic               mbus_req_o,
  input logic               mbus_ack_i,
  input logic [MAIN_AW-1:0] mbus_addr_o
);
  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbus_req_o && !mbus_ack_i |=> mbus_req_o && $stable(mbus_addr_o));

  a_r6_stall_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbus_req_o |-> cop_wait_o);

  a_r9_done_ends_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_done_o |-> !cop_wait_o && $past(cop_wait_o));

  a_r7_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_re_o, ram_we_o, fm_re_o, fm_we_o, psg_we_o, mbus_req_o}));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cop_wait_o |-> !(ram_re_o || ram_we_o || fm_re_o || fm_we_o || psg_we_o || mbus_req_o));
endmodule

bind cop_addr_map cop_addr_map_chk #(.MAIN_AW(MAIN_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cop_wait_o  (cop_wait_o),
  .cop_done_o  (cop_done_o),
  .ram_re_o    (ram_re_o),
  .ram_we_o    (ram_we_o),
  .fm_re_o     (fm_re_o),
  .fm_we_o     (fm_we_o),
  .psg_we_o    (psg_we_o),
  .mbus_req_o  (mbus_req_o),
  .mbus_ack_i  (mbus_ack_i),
  .mbus_addr_o (mbus_addr_o)
);

// File: tb/cop_addr_map_test.sv
module cop_addr_map_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        c_req = 0, c_we = 0, c_wide = 0;
  logic [15:0] c_addr = '0, c_wdata = '0;
  logic [15:0] c_rdata;
  logic        c_wait, c_done;
  logic        ram_re, ram_we, fm_re, fm_we, psg_we, mb_req, mb_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata, fm_wdata, psg_wdata, mb_wdata;
  logic [7:0]  fm_status = 8'h00;
  logic [7:0]  mb_rdata = 8'h00;
  logic        mb_ack = 1'b0;
  logic [1:0]  fm_addr;
  logic [23:0] mb_addr;

  cop_addr_map uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cop_req_i(c_req), .cop_we_i(c_we), .cop_wide_i(c_wide),
    .cop_addr_i(c_addr), .cop_wdata_i(c_wdata), .cop_rdata_o(c_rdata),
    .cop_wait_o(c_wait), .cop_done_o(c_done),
    .ram_re_o(ram_re), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .fm_re_o(fm_re), .fm_we_o(fm_we), .fm_addr_o(fm_addr),
    .fm_wdata_o(fm_wdata), .fm_status_i(fm_status),
    .psg_we_o(psg_we), .psg_wdata_o(psg_wdata),
    .mbus_req_o(mb_req), .mbus_we_o(mb_we), .mbus_addr_o(mb_addr),
    .mbus_wdata_o(mb_wdata), .mbus_rdata_i(mb_rdata), .mbus_ack_i(mb_ack)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // event kinds: 0 ram rd, 1 ram wr, 2 fm rd, 3 fm wr, 4 psg wr, 5 mbus rd, 6 mbus wr
  typedef struct {int kind; int addr; int data;} ev_t;
  ev_t exp_q[$];

  logic [7:0] dev_ram [8192];
  int         ref_ram [8192];
  int         ref_bank = 0;
  int         ack_delay = 0;
  int         mb_cnt = 0;
  int         last_mb_addr = -1;

  assign ram_rdata = dev_ram[ram_addr];
  always @(posedge clk) if (ram_we) dev_ram[ram_addr] <= ram_wdata;

  function automatic int mb_val(int a);
    return (a ^ (a >> 8) ^ (a >> 16) ^ 32'h5A) & 255;
  endfunction

  function automatic string kind_tag(int k);
    if (k <= 1) return "R1";
    if (k <= 3) return "R2";
    if (k == 4) return "R4";
    return "R5";
  endfunction

  // behavioural reference: expected side effects and read value
  task automatic predict(bit we, bit wide, int addr, int wdata, output int rexp);
    rexp = 0;
    for (int i = 0; i < (wide ? 2 : 1); i++) begin
      ev_t e;
      int  a;
      int  d;
      int  r;
      a = (addr + i) & 32'hFFFF;
      d = i ? ((wdata >> 8) & 255) : (wdata & 255);
      r = 0;
      e.kind = -1; e.addr = 0; e.data = we ? d : 0;
      if (a >= 32'h8000) begin
        e.kind = we ? 6 : 5;
        e.addr = (ref_bank << 15) | (a & 32'h7FFF);
        r = mb_val(e.addr);
      end else if (a < 32'h4000) begin
        e.kind = we ? 1 : 0;
        e.addr = a & 32'h1FFF;
        if (we) ref_ram[e.addr] = d; else r = ref_ram[e.addr];
      end else if (a < 32'h6000) begin
        e.kind = we ? 3 : 2;
        e.addr = a & 3;
        r = int'(fm_status);
      end else if ((a >> 8) == 32'h60) begin
        if (we) ref_bank = (ref_bank >> 1) | ((d & 1) << 8);
      end else if (((a & 32'hFFF9) == 32'h7F11) && we) begin
        e.kind = 4;
      end
      if (e.kind >= 0) exp_q.push_back(e);
      rexp |= r << (8 * i);
    end
  endtask

  // per-clock monitor: compares every strobe with the reference and drives the main bus
  always @(negedge clk) begin
    int k;
    int a;
    int d;
    k = -1; a = 0; d = 0;
    if (rst_n) begin
      if (ram_re)      begin k = 0; a = int'(ram_addr); end
      else if (ram_we) begin k = 1; a = int'(ram_addr); d = int'(ram_wdata); end
      else if (fm_re)  begin k = 2; a = int'(fm_addr); end
      else if (fm_we)  begin k = 3; a = int'(fm_addr); d = int'(fm_wdata); end
      else if (psg_we) begin k = 4; d = int'(psg_wdata); end
      if (mb_ack) begin
        mb_ack = 1'b0;
      end else if (mb_req) begin
        check(c_wait == 1'b1, "R6", int'(c_wait), 1);
        if (exp_q.size() > 0)
          check(int'(mb_addr) == exp_q[0].addr, "R6", int'(mb_addr), exp_q[0].addr);
        if (mb_cnt <= 0) begin
          mb_ack = 1'b1;
          mb_rdata = 8'(mb_val(int'(mb_addr)));
          k = mb_we ? 6 : 5;
          a = int'(mb_addr);
          d = mb_we ? int'(mb_wdata) : 0;
          last_mb_addr = a;
          mb_cnt = ack_delay;
        end else begin
          mb_cnt--;
        end
      end
      if (k >= 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", k, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(k == e.kind && a == e.addr, kind_tag(e.kind), (k << 24) | a, (e.kind << 24) | e.addr);
          check(d == e.data, kind_tag(e.kind), d, e.data);
        end
      end
    end
  end

  task automatic do_access(bit we, bit wide, int addr, int wdata, string tag);
    int rexp;
    int guard;
    predict(we, wide, addr, wdata, rexp);
    @(negedge clk);
    mb_cnt = ack_delay;
    c_req = 1'b1; c_we = we; c_wide = wide;
    c_addr = 16'(addr); c_wdata = 16'(wdata);
    @(negedge clk);
    c_req = 1'b0;
    check(c_wait == 1'b1, "R9", int'(c_wait), 1);
    guard = 0;
    while (!c_done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    check(c_done == 1'b1, "R9", int'(c_done), 1);
    if (!we) check(int'(c_rdata) == rexp, tag, int'(c_rdata), rexp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin
      dev_ram[i] = 8'((i * 7) & 255);
      ref_ram[i] = (i * 7) & 255;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(c_wait == 0 && c_done == 0, "R9", int'({c_wait, c_done}), 0);
    check(!(ram_re || ram_we || fm_re || fm_we || psg_we || mb_req), "R9",
          int'({ram_re, ram_we, fm_re, fm_we, psg_we, mb_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: bank is zero out of reset, seen through a window read
    do_access(0, 0, 32'h8000, 0, "R5");
    check(last_mb_addr == 0, "R3", last_mb_addr, 0);

    // R1: mirrored RAM
    do_access(1, 0, 32'h0123, 32'hAB, "R1");
    do_access(0, 0, 32'h2123, 0, "R1");
    do_access(0, 0, 32'h0777, 0, "R1");

    // R8: 16-bit RAM access
    do_access(1, 1, 32'h1000, 32'hBEEF, "R8");
    do_access(0, 1, 32'h3000, 0, "R8");

    // R2: FM chip
    fm_status = 8'h81;
    do_access(0, 0, 32'h4000, 0, "R2");
    do_access(1, 0, 32'h5FFE, 32'h22, "R2");
    fm_status = 8'h3C;
    do_access(0, 1, 32'h4001, 0, "R2");

    // R4: PSG writes, reads give zero
    do_access(1, 0, 32'h7F13, 32'h9F, "R4");
    do_access(1, 0, 32'h7F17, 32'h40, "R4");
    do_access(0, 0, 32'h7F11, 0, "R4");

    // R7: unmapped
    do_access(1, 0, 32'h7F19, 32'h11, "R7");
    do_access(1, 0, 32'h7F00, 32'h12, "R7");
    do_access(0, 0, 32'h6123, 0, "R7");
    do_access(0, 1, 32'h7000, 0, "R7");
    do_access(0, 0, 32'h6000, 0, "R7");

    // R3: load page 0x1A5 one bit at a time
    for (int b = 0; b < 9; b++) do_access(1, 0, 32'h6000 + b, (32'h1A5 >> b) & 1, "R3");
    do_access(0, 0, 32'hC123, 0, "R5");
    check(last_mb_addr == ((32'h1A5 << 15) | 32'h4123), "R3", last_mb_addr, (32'h1A5 << 15) | 32'h4123);

    // R3 / R8: wide write at 0x60FF: only the low byte shifts the bank
    do_access(1, 1, 32'h60FF, 32'h0001, "R3");
    do_access(0, 0, 32'h8001, 0, "R5");
    check(last_mb_addr == ((ref_bank << 15) | 1), "R3", last_mb_addr, (ref_bank << 15) | 1);

    // R6: delayed acknowledge, window writes and reads
    ack_delay = 3;
    do_access(1, 0, 32'h9000, 32'h5D, "R6");
    do_access(0, 0, 32'hA5A5, 0, "R6");
    do_access(1, 1, 32'hFFF0, 32'hC3D4, "R8");
    // R8: wide read wrapping from window into RAM
    do_access(0, 1, 32'hFFFF, 0, "R8");
    ack_delay = 1;
    do_access(0, 1, 32'hBFFE, 0, "R8");
    // R8: wide read straddling RAM and FM
    do_access(0, 1, 32'h3FFF, 0, "R8");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule